// File: doc/BRIEF.md
# Configurable Serial Receive Deserializer

This block turns an asynchronous serial line into characters for a receive path of a 16550-class UART. It runs on the system clock and advances its bit timing only on a 16x oversampling tick supplied by an external baud divider. The line is watched continuously. A falling level on an armed idle line starts a candidate start bit. The candidate is confirmed half a bit later. Data bits, an optional parity bit and the stop bit are then sampled at the centre of each bit period.

The character length (5 to 8 bits) and the parity mode (none, odd, even) are run-time inputs. They are captured when a start bit is confirmed. Each completed character carries three flags: parity error, framing error and break. A mode input steers each finished character to one of two places. In queue mode it goes out as a one-cycle write strobe toward an external receive FIFO. In direct mode it goes into an internal single-entry hold register that the host clears with a read strobe, and that register detects overrun.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `push_valid_o`, `buf_valid_o` and `buf_ovr_o` are 0.
- R2: A low level seen on an armed idle line becomes a start bit only if the line is still low 8 ticks later. A shorter low pulse produces no character, and the receiver goes back to idle.
- R3: Data bits are sampled 16 ticks apart, least significant bit first. `cfg_len_i` sets the length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Result bits above the length read 0.
- R4: When `cfg_par_en_i` is 1, one parity bit follows the data. With `cfg_par_even_i` = 1 the data bits plus the parity bit must hold an even count of ones; with 0 the count must be odd. A mismatch sets the parity error flag. With parity disabled, no parity bit is expected and the flag is 0.
- R5: A stop bit that samples low sets the framing error flag.
- R6: A character whose data, parity and stop bits all sample low is reported with the break flag set, framing error set and data 0. Afterwards no new start is accepted until the line has been seen high.
- R7: In queue mode (`fifo_mode_i` = 1), each character produces exactly one single-cycle `push_valid_o` pulse with its data and flags, and the hold register is untouched.
- R8: In direct mode (`fifo_mode_i` = 0), a character sets `buf_valid_o` and holds its data and flags until `buf_read_i` is pulsed, which clears `buf_valid_o`. No push pulse is produced.
- R9: In direct mode, a character that completes while `buf_valid_o` is 1 sets `buf_ovr_o` and replaces the held data. `buf_read_i` clears `buf_ovr_o`.
- R10: Length and parity settings are captured at start confirmation. Changing them later in the same character has no effect on that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 16x oversampling enable, one clock wide |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| cfg_len_i | input | 2 | Character length code (0..3 = 5..8 bits) |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| fifo_mode_i | input | 1 | 1 = queue path, 0 = hold register |
| buf_read_i | input | 1 | Host read strobe for the hold register |
| push_valid_o | output | 1 | Queue write strobe |
| push_data_o | output | 8 | Queue write data |
| push_perr_o | output | 1 | Queue parity error flag |
| push_ferr_o | output | 1 | Queue framing error flag |
| push_brk_o | output | 1 | Queue break flag |
| buf_valid_o | output | 1 | Hold register holds an unread character |
| buf_data_o | output | 8 | Held character |
| buf_perr_o | output | 1 | Held parity error flag |
| buf_ferr_o | output | 1 | Held framing error flag |
| buf_brk_o | output | 1 | Held break flag |
| buf_ovr_o | output | 1 | Overrun: a character replaced an unread one |

## Verification
The bench sends a low pulse shorter than half a bit. A receiver that does not qualify the start would emit a garbage character there. The bench holds the line low across a whole character and beyond. A receiver that re-arms on a low level would report a second, bogus break after the first. It reconfigures length and parity during the first data bit. A receiver that reads the settings live would cut the character short or invent a parity error. It lets two characters complete with no read in between, to catch an overrun flag that is not raised or an old byte that is kept instead of the new one.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RESET_VAL;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] cfg_len_i,
  input  logic       cfg_par_en_i,
  input  logic       cfg_par_even_i,
  output logic       done_o,
  output rx_char_t   char_o
);

  localparam int CW        = $clog2(OVS);
  localparam int BW        = $clog2(DW);
  localparam int HALF      = OVS / 2;
  localparam int LAST_BASE = DW - 4;

  rx_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [BW-1:0]  idx_q, idx_d;
  logic [BW-1:0]  last_q, last_d;
  logic [DW-1:0]  shr_q, shr_d;
  logic           par_q, par_d;
  logic           any1_q, any1_d;
  logic           pen_q, pen_d;
  logic           peven_q, peven_d;
  logic           armed_q, armed_d;
  logic           done_q, done_d;
  rx_char_t       char_q, char_d;

  logic mid_bit;
  logic conf_pt;
  logic par_mis;

  assign mid_bit = tick_i && (cnt_q == CW'(OVS - 1));
  assign conf_pt = tick_i && (cnt_q == CW'(HALF - 1));
  assign par_mis = (^shr_q) ^ par_q ^ peven_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    last_d  = last_q;
    shr_d   = shr_q;
    par_d   = par_q;
    any1_d  = any1_q;
    pen_d   = pen_q;
    peven_d = peven_q;
    done_d  = 1'b0;
    char_d  = char_q;
    armed_d = (state_q == RX_IDLE) ? (armed_q | rx_i) : 1'b0;

    unique case (state_q)
      RX_IDLE: begin
        if (tick_i && armed_q && !rx_i) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
      end

      RX_START: begin
        if (conf_pt) begin
          cnt_d = '0;
          if (!rx_i) begin
            state_d = RX_DATA;
            idx_d   = '0;
            shr_d   = '0;
            any1_d  = 1'b0;
            par_d   = 1'b0;
            last_d  = BW'(LAST_BASE) + BW'(cfg_len_i);
            pen_d   = cfg_par_en_i;
            peven_d = cfg_par_even_i;
          end else begin
            state_d = RX_IDLE;
          end
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      RX_DATA: begin
        if (mid_bit) begin
          cnt_d        = '0;
          shr_d[idx_q] = rx_i;
          any1_d       = any1_q | rx_i;
          if (idx_q == last_q) begin
            state_d = pen_q ? RX_PAR : RX_STOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      RX_PAR: begin
        if (mid_bit) begin
          cnt_d   = '0;
          par_d   = rx_i;
          any1_d  = any1_q | rx_i;
          state_d = RX_STOP;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      RX_STOP: begin
        if (mid_bit) begin
          cnt_d       = '0;
          done_d      = 1'b1;
          char_d.data = 8'(shr_q);
          char_d.perr = pen_q & ~par_mis;
          char_d.ferr = ~rx_i;
          char_d.brk  = ~rx_i & ~any1_q;
          state_d     = RX_IDLE;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      shr_q   <= '0;
      par_q   <= 1'b0;
      any1_q  <= 1'b0;
      pen_q   <= 1'b0;
      peven_q <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      shr_q   <= shr_d;
      par_q   <= par_d;
      any1_q  <= any1_d;
      pen_q   <= pen_d;
      peven_q <= peven_d;
      armed_q <= armed_d;
      done_q  <= done_d;
      char_q  <= char_d;
    end
  end

  assign done_o = done_q;
  assign char_o = char_q;

endmodule

// File: rtl/uart_rx_holdbuf.sv
module uart_rx_holdbuf
  import uart_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  rx_char_t char_i,
  input  logic     rd_i,
  output logic     valid_o,
  output rx_char_t char_o,
  output logic     ovr_o
);

  logic     valid_q, valid_d;
  logic     ovr_q, ovr_d;
  rx_char_t char_q, char_d;

  always_comb begin
    valid_d = valid_q;
    ovr_d   = ovr_q;
    char_d  = char_q;
    if (load_i) begin
      char_d  = char_i;
      valid_d = 1'b1;
      ovr_d   = (valid_q & ~rd_i) | (ovr_q & ~rd_i);
    end else if (rd_i) begin
      valid_d = 1'b0;
      ovr_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
      char_q  <= char_d;
    end
  end

  assign valid_o = valid_q;
  assign ovr_o   = ovr_q;
  assign char_o  = char_q;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] cfg_len_i,
  input  logic       cfg_par_en_i,
  input  logic       cfg_par_even_i,
  input  logic       fifo_mode_i,
  input  logic       buf_read_i,
  output logic       push_valid_o,
  output logic [7:0] push_data_o,
  output logic       push_perr_o,
  output logic       push_ferr_o,
  output logic       push_brk_o,
  output logic       buf_valid_o,
  output logic [7:0] buf_data_o,
  output logic       buf_perr_o,
  output logic       buf_ferr_o,
  output logic       buf_brk_o,
  output logic       buf_ovr_o
);

  localparam int DW = 8;

  logic     rx_s;
  logic     done;
  rx_char_t frm_char;
  rx_char_t hold_char;

  uart_rx_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (rxd_i),
    .q_o  (rx_s)
  );

  uart_rx_frame #(
    .OVS(OVS),
    .DW (DW)
  ) i_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .rx_i          (rx_s),
    .cfg_len_i     (cfg_len_i),
    .cfg_par_en_i  (cfg_par_en_i),
    .cfg_par_even_i(cfg_par_even_i),
    .done_o        (done),
    .char_o        (frm_char)
  );

  uart_rx_holdbuf i_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (done & ~fifo_mode_i),
    .char_i (frm_char),
    .rd_i   (buf_read_i),
    .valid_o(buf_valid_o),
    .char_o (hold_char),
    .ovr_o  (buf_ovr_o)
  );

  assign push_valid_o = done & fifo_mode_i;
  assign push_data_o  = frm_char.data;
  assign push_perr_o  = frm_char.perr;
  assign push_ferr_o  = frm_char.ferr;
  assign push_brk_o   = frm_char.brk;

  assign buf_data_o = hold_char.data;
  assign buf_perr_o = hold_char.perr;
  assign buf_ferr_o = hold_char.ferr;
  assign buf_brk_o  = hold_char.brk;

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       push_valid_o,
  input logic [7:0] push_data_o,
  input logic       push_ferr_o,
  input logic       push_brk_o,
  input logic       buf_valid_o,
  input logic       buf_ovr_o
);

  // R7
  push_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_o |=> !push_valid_o);

  // R6
  break_implies_ferr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid_o && push_brk_o) |-> (push_ferr_o && push_data_o == 8'h00));

  // R9
  ovr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ovr_o |-> buf_valid_o);

  // R9
  ovr_rise_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_ovr_o) |-> $past(buf_valid_o));

endmodule

bind uart_rx_core uart_rx_core_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_valid_o(push_valid_o),
  .push_data_o (push_data_o),
  .push_ferr_o (push_ferr_o),
  .push_brk_o  (push_brk_o),
  .buf_valid_o (buf_valid_o),
  .buf_ovr_o   (buf_ovr_o)
);

// File: tb/test_uart_rx_core.sv
`timescale 1ns/1ps
module test_uart_rx_core;

  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i;
  logic       rxd_i;
  logic [1:0] cfg_len_i;
  logic       cfg_par_en_i;
  logic       cfg_par_even_i;
  logic       fifo_mode_i;
  logic       buf_read_i;
  logic       push_valid_o;
  logic [7:0] push_data_o;
  logic       push_perr_o;
  logic       push_ferr_o;
  logic       push_brk_o;
  logic       buf_valid_o;
  logic [7:0] buf_data_o;
  logic       buf_perr_o;
  logic       buf_ferr_o;
  logic       buf_brk_o;
  logic       buf_ovr_o;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int         pushes = 0;
  logic [7:0] m_data;
  logic       m_perr, m_ferr, m_brk;
  logic [1:0] tdiv_q = '0;

  always #10 clk = ~clk;

  always @(posedge clk) tdiv_q <= tdiv_q + 2'd1;
  assign tick_i = (tdiv_q == 2'(TDIV - 1));

  uart_rx_core i_uart_rx_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .rxd_i         (rxd_i),
    .cfg_len_i     (cfg_len_i),
    .cfg_par_en_i  (cfg_par_en_i),
    .cfg_par_even_i(cfg_par_even_i),
    .fifo_mode_i   (fifo_mode_i),
    .buf_read_i    (buf_read_i),
    .push_valid_o  (push_valid_o),
    .push_data_o   (push_data_o),
    .push_perr_o   (push_perr_o),
    .push_ferr_o   (push_ferr_o),
    .push_brk_o    (push_brk_o),
    .buf_valid_o   (buf_valid_o),
    .buf_data_o    (buf_data_o),
    .buf_perr_o    (buf_perr_o),
    .buf_ferr_o    (buf_ferr_o),
    .buf_brk_o     (buf_brk_o),
    .buf_ovr_o     (buf_ovr_o)
  );

  always @(negedge clk) begin
    if (rst_n && push_valid_o) begin
      pushes <= pushes + 1;
      m_data <= push_data_o;
      m_perr <= push_perr_o;
      m_ferr <= push_ferr_o;
      m_brk  <= push_brk_o;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bit_time(input int n);
    repeat (n * BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] len,
                            input bit pen, input bit peven, input bit pflip,
                            input bit stopv, input bit mid_cfg);
    int nb;
    logic [7:0] md;
    logic p;
    nb = 5 + int'(len);
    md = d & 8'((1 << nb) - 1);
    p  = (peven ? (^md) : ~(^md)) ^ pflip;
    rxd_i = 1'b0;
    bit_time(1);
    if (mid_cfg) begin
      cfg_len_i    = 2'd0;
      cfg_par_en_i = 1'b1;
    end
    for (int i = 0; i < nb; i++) begin
      rxd_i = md[i];
      bit_time(1);
    end
    if (pen) begin
      rxd_i = p;
      bit_time(1);
    end
    rxd_i = stopv;
    bit_time(1);
    rxd_i = 1'b1;
    bit_time(1);
  endtask

  task automatic set_cfg(input logic [1:0] len, input bit pen, input bit peven);
    cfg_len_i      = len;
    cfg_par_en_i   = pen;
    cfg_par_even_i = peven;
  endtask

  task automatic t_reset;
    chk("R1", "push_valid after reset", int'(push_valid_o), 0);
    chk("R1", "buf_valid after reset", int'(buf_valid_o), 0);
    chk("R1", "buf_ovr after reset", int'(buf_ovr_o), 0);
  endtask

  task automatic t_lengths;
    int p0;
    set_cfg(2'd0, 1'b0, 1'b0);
    p0 = pushes;
    send_frame(8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3", "5-bit data", int'(m_data), 8'h1F);
    chk("R7", "one push per char", pushes - p0, 1);
    set_cfg(2'd1, 1'b0, 1'b0);
    send_frame(8'h2A, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3", "6-bit data", int'(m_data), 8'h2A);
    set_cfg(2'd3, 1'b0, 1'b0);
    send_frame(8'hB4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3", "8-bit data lsb first", int'(m_data), 8'hB4);
    chk("R4", "no parity perr", int'(m_perr), 0);
    chk("R7", "buffer untouched in queue mode", int'(buf_valid_o), 0);
  endtask

  task automatic t_parity;
    set_cfg(2'd2, 1'b1, 1'b1);
    send_frame(8'h35, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R4", "even good perr", int'(m_perr), 0);
    chk("R4", "even good data", int'(m_data), 8'h35);
    send_frame(8'h35, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R4", "even bad perr", int'(m_perr), 1);
    set_cfg(2'd3, 1'b1, 1'b0);
    send_frame(8'hC3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4", "odd good perr", int'(m_perr), 0);
    send_frame(8'hC3, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R4", "odd bad perr", int'(m_perr), 1);
  endtask

  task automatic t_framing;
    set_cfg(2'd3, 1'b0, 1'b0);
    send_frame(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5", "ferr on low stop", int'(m_ferr), 1);
    chk("R5", "no brk with data ones", int'(m_brk), 0);
    send_frame(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5", "ferr clear on good stop", int'(m_ferr), 0);
  endtask

  task automatic t_break;
    int p0;
    set_cfg(2'd3, 1'b0, 1'b0);
    p0 = pushes;
    rxd_i = 1'b0;
    bit_time(14);
    rxd_i = 1'b1;
    bit_time(2);
    chk("R6", "single break char", pushes - p0, 1);
    chk("R6", "brk flag", int'(m_brk), 1);
    chk("R6", "brk ferr", int'(m_ferr), 1);
    chk("R6", "brk data", int'(m_data), 0);
    send_frame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6", "char after break", int'(m_data), 8'h5A);
    chk("R6", "count after break", pushes - p0, 2);
  endtask

  task automatic t_glitch;
    int p0;
    p0 = pushes;
    rxd_i = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxd_i = 1'b1;
    bit_time(3);
    chk("R2", "glitch ignored", pushes - p0, 0);
    send_frame(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2", "char after glitch", int'(m_data), 8'h3C);
  endtask

  task automatic t_cfg_latch;
    set_cfg(2'd3, 1'b0, 1'b0);
    send_frame(8'hE7, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10", "length kept", int'(m_data), 8'hE7);
    chk("R10", "parity off kept", int'(m_perr), 0);
    chk("R10", "no ferr", int'(m_ferr), 0);
    set_cfg(2'd3, 1'b0, 1'b0);
  endtask

  task automatic t_buffer;
    int p0;
    fifo_mode_i = 1'b0;
    p0 = pushes;
    send_frame(8'h11, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8", "buf valid", int'(buf_valid_o), 1);
    chk("R8", "buf data", int'(buf_data_o), 8'h11);
    chk("R8", "no push in direct mode", pushes - p0, 0);
    chk("R9", "no ovr yet", int'(buf_ovr_o), 0);
    send_frame(8'h22, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "ovr set", int'(buf_ovr_o), 1);
    chk("R9", "data overwritten", int'(buf_data_o), 8'h22);
    chk("R8", "held ferr", int'(buf_ferr_o), 1);
    @(negedge clk);
    buf_read_i = 1'b1;
    @(negedge clk);
    buf_read_i = 1'b0;
    chk("R8", "read clears valid", int'(buf_valid_o), 0);
    chk("R9", "read clears ovr", int'(buf_ovr_o), 0);
    send_frame(8'h44, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9", "no ovr after read", int'(buf_ovr_o), 0);
    chk("R8", "new data", int'(buf_data_o), 8'h44);
  endtask

  initial begin
    rst_n          = 1'b0;
    rxd_i          = 1'b1;
    buf_read_i     = 1'b0;
    fifo_mode_i    = 1'b1;
    cfg_len_i      = 2'd3;
    cfg_par_en_i   = 1'b0;
    cfg_par_even_i = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    bit_time(1);
    t_lengths();
    t_parity();
    t_framing();
    t_break();
    t_glitch();
    t_cfg_latch();
    t_buffer();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule